// File: doc/BRIEF.md
# Policy-Driven Clock Source Selector

This block picks which of four clock-enable sources drives a processor clock tick and divides that source down by a programmable ratio. The sources are a crystal tick, a system tick, a slow PLL-channel tick and a fast PLL-channel tick. All of them are single-cycle enables in one system clock domain. A small register file holds four words: a packed table of 3-bit frequency IDs, one per policy; a select word that can force a policy; and two 8-bit post-divider values for the PLL channels.

Each cycle the selected policy picks a frequency ID from the table. An externally reported active ID wins over that choice when it is present and differs. The resulting ID chooses the source and the divide ratio. The output emits one tick for every N ticks of the chosen source. Status outputs give the effective ID, the ratio, and flags for a bad policy, a bad ID and an active-ID override.

Top module: `clk_policy_sel`

## Requirements
- R1: After reset all configuration is zero, so the crystal (ID 0) is selected, the reported ratio is 1 and no error or override flag is set.
- R2: Register writes land one cycle after the write strobe. The address decode is 0 = ID table, 1 = select word, 2 = slow divider, 3 = fast divider. In the select word, bit 4 is the force bit and bits [3:0] are the policy number; with the force bit clear, policy 0 is used. The ID for policy p is bits [8p+2:8p] of the table word.
- R3: A policy number above 3 sets the policy error flag and holds the output tick low. While this holds, the policy-derived ID is taken as 0.
- R4: When the active-ID valid input is high, the active ID becomes the effective ID. The override flag is high exactly when that active ID differs from the policy-derived ID.
- R5: ID 0 selects the crystal, 2 the system tick, 6 the slow channel and 7 the fast channel. Any other ID sets the ID error flag and holds the output tick low.
- R6: The ratio is 1 for IDs 0 and 2, the slow divider for ID 6 and the fast divider for ID 7. A divider value of 0 means 256. An invalid ID reports a ratio of 1.
- R7: The output tick is high for one cycle, in the cycle after every N-th tick of the selected source, where N is the ratio. Ticks of unselected sources are not counted.
- R8: In any cycle where the effective ID or the ratio differs from its value in the previous cycle, the divide count restarts from zero. That cycle's source tick is not counted, and no output tick follows that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register index |
| wr_data_i | input | 32 | Write data |
| act_vld_i | input | 1 | Active-ID status present |
| act_fid_i | input | 3 | Active frequency ID |
| xtal_tick_i | input | 1 | Crystal source tick |
| sys_tick_i | input | 1 | System source tick |
| slow_tick_i | input | 1 | Slow PLL channel tick |
| fast_tick_i | input | 1 | Fast PLL channel tick |
| tick_o | output | 1 | Divided output tick |
| div_ratio_o | output | 9 | Effective divide ratio |
| fid_o | output | 3 | Effective frequency ID |
| pol_err_o | output | 1 | Policy number out of range |
| fid_err_o | output | 1 | Effective ID invalid |
| fid_ovr_o | output | 1 | Active ID overrode policy ID |

## Verification
Two events can fall in the same cycle: a terminal source tick that would complete a divide period, and a change of effective ID or ratio that restarts the count. Random stimulus provokes this by rewriting dividers and select words, and by toggling the active-ID input while all four sources tick densely. A cycle-accurate bench model judges each case and expects the restart to win, so no output tick follows. A directed sequence also writes a divider of zero and runs 256 slow ticks to confirm the wrap.

// File: rtl/cps_pkg.sv
// Shared constants for the policy-driven clock source selector.
package cps_pkg;
    localparam int FID_W   = 3;
    localparam int DIV_W   = 8;
    localparam int RATIO_W = DIV_W + 1;
    localparam int NSRC    = 4;

    localparam logic [FID_W-1:0] FID_XTAL = 3'd0;
    localparam logic [FID_W-1:0] FID_SYS  = 3'd2;
    localparam logic [FID_W-1:0] FID_SLOW = 3'd6;
    localparam logic [FID_W-1:0] FID_FAST = 3'd7;

    // register indices
    localparam logic [1:0] REG_TABLE = 2'd0;
    localparam logic [1:0] REG_SEL   = 2'd1;
    localparam logic [1:0] REG_SLOW  = 2'd2;
    localparam logic [1:0] REG_FAST  = 2'd3;
endpackage

// File: rtl/cps_cfg_regs.sv
// Configuration storage. Keeps only the bits that the selector decodes:
// the per-policy ID fields, the force bit, the policy number and two dividers.
// Assumes writes are single-cycle strobes; all fields reset to zero.
module cps_cfg_regs
    import cps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPOL   = 4,
    parameter int STRIDE = 8,
    parameter int POL_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NPOL-1:0][FID_W-1:0] tbl_fid,
    output logic                       sel_force,
    output logic [POL_W-1:0]           sel_pol,
    output logic [DIV_W-1:0]           slow_div,
    output logic [DIV_W-1:0]           fast_div
);
    localparam int FORCE_BIT = POL_W;

    // per-policy ID field storage
    for (genvar p = 0; p < NPOL; p++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_fid[p] <= '0;
            else if (wr_en && wr_addr == REG_TABLE)
                tbl_fid[p] <= wr_data[p*STRIDE +: FID_W];
        end
    end

    // select word and divider storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_force <= 1'b0;
            sel_pol   <= '0;
            slow_div  <= '0;
            fast_div  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_SEL: begin
                    sel_force <= wr_data[FORCE_BIT];
                    sel_pol   <= wr_data[POL_W-1:0];
                end
                REG_SLOW: slow_div <= wr_data[DIV_W-1:0];
                REG_FAST: fast_div <= wr_data[DIV_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cps_fid_resolve.sv
// Combinational resolution of policy -> frequency ID -> source and ratio.
// Assumes the active-ID input is already synchronous to clk.
module cps_fid_resolve
    import cps_pkg::*;
#(
    parameter int NPOL  = 4,
    parameter int POL_W = 4
) (
    input  logic [NPOL-1:0][FID_W-1:0] tbl_fid,
    input  logic                       sel_force,
    input  logic [POL_W-1:0]           sel_pol,
    input  logic [DIV_W-1:0]           slow_div,
    input  logic [DIV_W-1:0]           fast_div,
    input  logic                       act_vld,
    input  logic [FID_W-1:0]           act_fid,
    output logic [FID_W-1:0]           eff_fid,
    output logic [RATIO_W-1:0]         ratio,
    output logic [NSRC-1:0]            src_sel,
    output logic                       pol_err,
    output logic                       fid_err,
    output logic                       fid_ovr
);
    logic [POL_W-1:0] pol;
    logic [FID_W-1:0] pol_fid;

    // pick the policy and its table entry
    always_comb begin
        pol     = sel_force ? sel_pol : '0;
        pol_err = (pol > POL_W'(NPOL - 1));
        pol_fid = '0;
        for (int p = 0; p < NPOL; p++)
            if (!pol_err && pol == POL_W'(p))
                pol_fid = tbl_fid[p];
    end

    // active status wins when present
    always_comb begin
        eff_fid = act_vld ? act_fid : pol_fid;
        fid_ovr = act_vld && (act_fid != pol_fid);
    end

    // source choice and divide ratio from the effective ID
    always_comb begin
        src_sel = '0;
        fid_err = 1'b0;
        ratio   = RATIO_W'(1);
        case (eff_fid)
            FID_XTAL: src_sel = 4'b0001;
            FID_SYS:  src_sel = 4'b0010;
            FID_SLOW: begin
                src_sel = 4'b0100;
                ratio   = (slow_div == '0) ? RATIO_W'(1 << DIV_W) : RATIO_W'(slow_div);
            end
            FID_FAST: begin
                src_sel = 4'b1000;
                ratio   = (fast_div == '0) ? RATIO_W'(1 << DIV_W) : RATIO_W'(fast_div);
            end
            default:  fid_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/cps_tick_div.sv
// Counts ticks of the selected source and emits one registered output tick
// per ratio ticks. Restarts when the ID or ratio changes. Assumes ratio >= 1.
module cps_tick_div
    import cps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    ticks,
    input  logic [NSRC-1:0]    src_sel,
    input  logic               gate,
    input  logic [FID_W-1:0]   eff_fid,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick_o
);
    logic [DIV_W-1:0]   cnt;
    logic [FID_W-1:0]   fid_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               src_tick;
    logic               restart;
    logic [RATIO_W-1:0] last;

    // selected tick and change detection
    always_comb begin
        src_tick = |(ticks & src_sel);
        restart  = (eff_fid != fid_q) || (ratio != ratio_q);
        last     = ratio - RATIO_W'(1);
    end

    // remember previous ID and ratio
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fid_q   <= FID_XTAL;
            ratio_q <= RATIO_W'(1);
        end else begin
            fid_q   <= eff_fid;
            ratio_q <= ratio;
        end
    end

    // divide counter and output tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (restart) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (gate && src_tick) begin
            if ({1'b0, cnt} == last) begin
                cnt    <= '0;
                tick_o <= 1'b1;
            end else begin
                cnt    <= cnt + DIV_W'(1);
                tick_o <= 1'b0;
            end
        end else begin
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_policy_sel.sv
// Top of the policy-driven clock source selector: register file, ID
// resolution and tick divider. Single clock domain, synchronous reset.
module clk_policy_sel
    import cps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPOL   = 4,
    parameter int STRIDE = 8,
    parameter int POL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               act_vld_i,
    input  logic [FID_W-1:0]   act_fid_i,
    input  logic               xtal_tick_i,
    input  logic               sys_tick_i,
    input  logic               slow_tick_i,
    input  logic               fast_tick_i,
    output logic               tick_o,
    output logic [RATIO_W-1:0] div_ratio_o,
    output logic [FID_W-1:0]   fid_o,
    output logic               pol_err_o,
    output logic               fid_err_o,
    output logic               fid_ovr_o
);
    logic [NPOL-1:0][FID_W-1:0] tbl_fid;
    logic                       sel_force;
    logic [POL_W-1:0]           sel_pol;
    logic [DIV_W-1:0]           slow_div;
    logic [DIV_W-1:0]           fast_div;
    logic [NSRC-1:0]            src_sel;

    cps_cfg_regs #(.DATA_W(DATA_W), .NPOL(NPOL), .STRIDE(STRIDE), .POL_W(POL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .tbl_fid(tbl_fid), .sel_force(sel_force),
        .sel_pol(sel_pol), .slow_div(slow_div), .fast_div(fast_div)
    );

    cps_fid_resolve #(.NPOL(NPOL), .POL_W(POL_W)) u_resolve (
        .tbl_fid(tbl_fid), .sel_force(sel_force), .sel_pol(sel_pol),
        .slow_div(slow_div), .fast_div(fast_div), .act_vld(act_vld_i),
        .act_fid(act_fid_i), .eff_fid(fid_o), .ratio(div_ratio_o),
        .src_sel(src_sel), .pol_err(pol_err_o), .fid_err(fid_err_o),
        .fid_ovr(fid_ovr_o)
    );

    cps_tick_div u_div (
        .clk(clk), .rst_n(rst_n),
        .ticks({fast_tick_i, slow_tick_i, sys_tick_i, xtal_tick_i}),
        .src_sel(src_sel), .gate(!pol_err_o && !fid_err_o),
        .eff_fid(fid_o), .ratio(div_ratio_o), .tick_o(tick_o)
    );
endmodule

// File: rtl/cps_chk.sv
// Property checker for clk_policy_sel, attached by bind.
module cps_chk
    import cps_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               act_vld_i,
    input logic [FID_W-1:0]   act_fid_i,
    input logic               tick_o,
    input logic [RATIO_W-1:0] div_ratio_o,
    input logic [FID_W-1:0]   fid_o,
    input logic               pol_err_o,
    input logic               fid_err_o,
    input logic               fid_ovr_o
);
    // R3
    pol_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_err_o |=> !tick_o);
    // R5
    fid_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fid_err_o |=> !tick_o);
    // R4
    act_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fid_ovr_o |-> (act_vld_i && fid_o == act_fid_i));
    // R6
    ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio_o != '0) && (div_ratio_o <= RATIO_W'(256)));
    // R6
    unit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fid_o == FID_XTAL || fid_o == FID_SYS) |-> div_ratio_o == RATIO_W'(1));
    // R8
    fid_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fid_o) |=> !tick_o);
    // R8
    ratio_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio_o) |=> !tick_o);
endmodule

bind clk_policy_sel cps_chk u_chk (
    .clk(clk), .rst_n(rst_n), .act_vld_i(act_vld_i), .act_fid_i(act_fid_i),
    .tick_o(tick_o), .div_ratio_o(div_ratio_o), .fid_o(fid_o),
    .pol_err_o(pol_err_o), .fid_err_o(fid_err_o), .fid_ovr_o(fid_ovr_o)
);

// File: tb/clk_policy_sel_tb.sv
// Self-checking bench: random plus directed stimulus against a reference model.
module clk_policy_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        act_vld = 1'b0;
    logic [2:0]  act_fid = '0;
    logic        t_x = 1'b0, t_s = 1'b0, t_l = 1'b0, t_f = 1'b0;
    logic        tick;
    logic [8:0]  ratio;
    logic [2:0]  fid;
    logic        perr, ferr, fovr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit dense = 0;

    always #5 clk = ~clk;

    clk_policy_sel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .act_vld_i(act_vld), .act_fid_i(act_fid),
        .xtal_tick_i(t_x), .sys_tick_i(t_s), .slow_tick_i(t_l), .fast_tick_i(t_f),
        .tick_o(tick), .div_ratio_o(ratio), .fid_o(fid), .pol_err_o(perr),
        .fid_err_o(ferr), .fid_ovr_o(fovr)
    );

    // reference model state (from the requirements)
    logic [2:0] m_tbl [4];
    logic       m_force;
    logic [3:0] m_pol;
    logic [7:0] m_slow, m_fast;
    logic [7:0] m_cnt;
    logic [2:0] m_fidq;
    logic [8:0] m_ratq;
    logic       m_tick;

    function automatic logic [3:0] e_pol();
        return m_force ? m_pol : 4'd0;
    endfunction
    function automatic logic e_perr();
        return e_pol() > 4'd3;
    endfunction
    function automatic logic [2:0] e_pfid();
        return e_perr() ? 3'd0 : m_tbl[e_pol()];
    endfunction
    function automatic logic [2:0] e_fid();
        return act_vld ? act_fid : e_pfid();
    endfunction
    function automatic logic e_ovr();
        return act_vld && act_fid != e_pfid();
    endfunction
    function automatic logic e_ferr();
        logic [2:0] f = e_fid();
        return !(f == 0 || f == 2 || f == 6 || f == 7);
    endfunction
    function automatic logic [8:0] e_ratio();
        logic [2:0] f = e_fid();
        if (f == 6) return (m_slow == 0) ? 9'd256 : {1'b0, m_slow};
        if (f == 7) return (m_fast == 0) ? 9'd256 : {1'b0, m_fast};
        return 9'd1;
    endfunction
    function automatic logic e_src();
        case (e_fid())
            3'd0: return t_x;
            3'd2: return t_s;
            3'd6: return t_l;
            3'd7: return t_f;
            default: return 1'b0;
        endcase
    endfunction

    // R2 R7 R8 model: registers and divide counter
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tbl[i] <= 3'd0;
            m_force <= 0; m_pol <= 0; m_slow <= 0; m_fast <= 0;
            m_cnt <= 0; m_fidq <= 0; m_ratq <= 9'd1; m_tick <= 0;
        end else begin
            m_fidq <= e_fid();
            m_ratq <= e_ratio();
            if (e_fid() != m_fidq || e_ratio() != m_ratq) begin
                m_cnt <= 0; m_tick <= 0;
            end else if (!e_perr() && !e_ferr() && e_src()) begin
                if ({1'b0, m_cnt} == e_ratio() - 9'd1) begin
                    m_cnt <= 0; m_tick <= 1;
                end else begin
                    m_cnt <= m_cnt + 8'd1; m_tick <= 0;
                end
            end else m_tick <= 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: for (int i = 0; i < 4; i++) m_tbl[i] <= wr_data[i*8 +: 3];
                    2'd1: begin m_force <= wr_data[4]; m_pol <= wr_data[3:0]; end
                    2'd2: m_slow <= wr_data[7:0];
                    default: m_fast <= wr_data[7:0];
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs every cycle away from the edge
    task automatic compare_all();
        chk("R7 tick", tick, m_tick);
        chk("R6 ratio", ratio, e_ratio());
        chk("R4/R5 fid", fid, e_fid());
        chk("R3 pol_err", perr, e_perr());
        chk("R5 fid_err", ferr, e_ferr());
        chk("R4 fid_ovr", fovr, e_ovr());
    endtask

    always @(negedge clk) if (rst_n && !done) compare_all();

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // source tick generator, driven on falling edges
    always @(negedge clk) begin
        if (dense) begin
            t_x <= 1; t_s <= ($urandom % 2) == 0; t_l <= 1; t_f <= 1;
        end else begin
            t_x <= ($urandom % 2) == 0; t_s <= ($urandom % 3) == 0;
            t_l <= ($urandom % 2) == 0; t_f <= ($urandom % 4) != 0;
        end
    end

    initial begin
        int ticks_seen;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fid", fid, 0);
        chk("R1 ratio", ratio, 1);
        chk("R1 errs", {perr, ferr, fovr}, 0);

        // R6 zero divider means 256 on the slow channel
        wr(2'd0, 32'h0000_0006);
        wr(2'd2, 32'h0);
        dense = 1;
        @(negedge clk);
        chk("R6 div256", ratio, 256);
        ticks_seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (tick) ticks_seen++;
        end
        chk("R7 wrap count", ticks_seen, 2);
        dense = 0;

        // R3 policy out of range
        wr(2'd1, 32'h0000_0015);
        chk("R3 flag", perr, 1);
        repeat (20) begin @(negedge clk); chk("R3 quiet", tick, 0); end

        // R2 forced policy 2 picks table bits [18:16], R5 invalid ID
        wr(2'd0, 32'h0003_0000);
        wr(2'd1, 32'h0000_0012);
        chk("R2 policy2", fid, 3);
        chk("R5 bad id", ferr, 1);
        repeat (20) begin @(negedge clk); chk("R5 quiet", tick, 0); end

        // R4 active status overrides
        act_vld = 1; act_fid = 3'd7;
        @(negedge clk);
        chk("R4 ovr", fovr, 1);
        chk("R4 fid", fid, 7);
        act_vld = 0;

        // R2 force clear returns to policy 0
        wr(2'd1, 32'h0000_0002);
        chk("R2 force clear", fid, 3'd3 & 3'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 16;
            dense = ($urandom % 4) == 0;
            if (r == 0) begin
                int tv = 0;
                for (int p = 0; p < 4; p++) begin
                    int c = $urandom % 5;
                    tv |= ((c == 0) ? 0 : (c == 1) ? 2 : (c == 2) ? 6 : (c == 3) ? 7 : ($urandom % 8)) << (8 * p);
                end
                wr(2'd0, tv);
            end else if (r == 1) wr(2'd1, {27'd0, 1'b1, 4'($urandom % 5)});
            else if (r == 2) wr(2'd1, 32'h0);
            else if (r == 3) wr(2'd2, $urandom % 6);
            else if (r == 4) wr(2'd3, $urandom % 6);
            else begin
                @(negedge clk);
                act_vld = ($urandom % 10) == 0;
                act_fid = 3'($urandom);
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule